// File: doc/BRIEF.md
# Cascadable Presettable Up/Down Counter

This block is a synchronous binary counter, four bits wide by default, that can be preset and can count in either direction. A parallel load strobe writes a data word into the count register. A direction input selects whether the register increments or decrements. The strobe and both enables are active low. Every change to the register happens on the rising clock edge. The count wraps around at both ends of its range.

Two enables allow stages to be chained. The count enable is shared by every stage of a chain. The carry-in enable of each stage is driven by the terminal-count output of the stage below it. The terminal-count output is decoded combinationally from three things: the current count, the carry-in enable and the direction. It goes low when the stage sits at the end of its range for the selected direction and its carry-in enable is asserted. Identical stages chained this way form one wider synchronous counter with no extra gating.

A synchronous active-low reset clears the count and ranks above every other control. It exists for simulation start-up.

Top module: `updn_cascade_ctr`

## Requirements
- R1: With `rst_n` low at a rising edge, `count` is 0 after that edge, whatever the levels of `load_n`, the enables and `din`.
- R2: With `rst_n` high and `load_n` low at a rising edge, `count` takes the value of `din` after that edge, whatever the levels of `cnt_en_n`, `carry_in_n` and `up_dn`.
- R3: With `load_n` high, `cnt_en_n` low, `carry_in_n` low and `up_dn` high (1 = up), `count` increases by one at the edge, and wraps from all ones (15) to 0.
- R4: With `load_n` high, both enables low and `up_dn` low (0 = down), `count` decreases by one at the edge, and wraps from 0 to all ones (15).
- R5: With `load_n` high and either `cnt_en_n` or `carry_in_n` high, `count` keeps its value at the edge.
- R6: `tc_n` is low only when `carry_in_n` is low and either `up_dn` is 1 with `count` at all ones, or `up_dn` is 0 with `count` at 0. Otherwise `tc_n` is high. It follows its inputs within the same cycle, and `load_n` and `cnt_en_n` have no effect on it.
- R7: Stages can be chained as a wider counter. In a chain, each stage's `tc_n` drives the next stage's `carry_in_n`, and `load_n`, `cnt_en_n` and `up_dn` are shared by all stages. Such a chain counts up and down as a single binary counter, including wrap-around and preset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous clear, active low |
| load_n | input | 1 | Parallel load strobe, active low |
| cnt_en_n | input | 1 | Shared count enable, active low |
| carry_in_n | input | 1 | Carry-in enable, active low; also gates `tc_n` |
| up_dn | input | 1 | Direction: 1 counts up, 0 counts down |
| din | input | WIDTH | Preset data word |
| count | output | WIDTH | Current count |
| tc_n | output | 1 | Terminal count, active low |

## Verification
The assertions check on every clock the cycle-level rules of a single stage:
- reset clears the count;
- a load captures `din`;
- the count steps by exactly one in the selected direction;
- the count holds when either enable is off;
- `tc_n` stays high whenever the carry-in is off, and drops at the terminal value.

Some behaviour only the bench scenarios can show:
- a wider count is carried correctly across a chain of stages;
- reset ranks above a simultaneous load;
- `tc_n` reacts within a cycle, with no clock edge, to a change of carry-in or direction.

// File: rtl/updn_ctr_pkg.sv
// Package: shared types for the cascadable up/down counter.
// Assumes: nothing beyond IEEE 1800-2017.
package updn_ctr_pkg;

    // Operation selected for the coming clock edge, in priority order.
    typedef enum logic [2:0] {
        OP_CLEAR = 3'd0,
        OP_LOAD  = 3'd1,
        OP_INC   = 3'd2,
        OP_DEC   = 3'd3,
        OP_HOLD  = 3'd4
    } ctr_op_e;

endpackage

// File: rtl/updn_ctr_op_sel.sv
// Module: picks the register operation from the control inputs.
// Priority: clear > load > count (both enables low) > hold.
// Assumes: all controls are synchronous to the clock of the register.
module updn_ctr_op_sel
    import updn_ctr_pkg::*;
(
    input  logic    rst_n,
    input  logic    load_n,
    input  logic    cnt_en_n,
    input  logic    carry_in_n,
    input  logic    up_dn,
    output ctr_op_e op
);

    // Priority decode of the control inputs into one operation.
    always_comb begin
        if (!rst_n)
            op = OP_CLEAR;
        else if (!load_n)
            op = OP_LOAD;
        else if (!cnt_en_n && !carry_in_n)
            op = up_dn ? OP_INC : OP_DEC;
        else
            op = OP_HOLD;
    end

endmodule

// File: rtl/updn_ctr_state.sv
// Module: count register with its next-state logic.
// Executes the operation chosen by the selector on each rising edge.
// Assumes: op is settled before the edge; wrap-around is natural modulo 2**WIDTH.
module updn_ctr_state
    import updn_ctr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctr_op_e          op,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] count,
    // Raw controls, used only by the local assertions.
    input  logic             load_n,
    input  logic             cnt_en_n,
    input  logic             carry_in_n,
    input  logic             up_dn
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    logic [WIDTH-1:0] nxt;

    // Next count for the selected operation.
    always_comb begin
        unique case (op)
            OP_CLEAR: nxt = '0;
            OP_LOAD:  nxt = din;
            OP_INC:   nxt = count + ONE;
            OP_DEC:   nxt = count - ONE;
            default:  nxt = count;
        endcase
    end

    // Register update on the rising edge.
    always_ff @(posedge clk) begin
        count <= nxt;
    end

    AST_CLEAR_WINS: assert property (@(posedge clk) !rst_n |=> count == '0); // R1
    AST_LOAD_TAKES_DIN: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> count == $past(din)); // R2
    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !cnt_en_n && !carry_in_n && up_dn) |=> count == $past(count) + ONE); // R3
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !cnt_en_n && !carry_in_n && !up_dn) |=> count == $past(count) - ONE); // R4
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && (cnt_en_n || carry_in_n)) |=> $stable(count)); // R5

endmodule

// File: rtl/updn_ctr_tc.sv
// Module: terminal-count decode, combinational and active low.
// Each bit is compared with the direction: all ones for up, all zeros for down.
// Assumes: only carry_in_n gates the result; load and count enable do not.
module updn_ctr_tc #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] count,
    input  logic             carry_in_n,
    input  logic             up_dn,
    output logic             tc_n
);

    logic [WIDTH-1:0] bit_at_end;

    // One comparator per bit against the end value for the direction.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign bit_at_end[i] = (count[i] == up_dn);
    end

    // Terminal flag, enabled by carry-in only.
    always_comb begin
        tc_n = !(!carry_in_n && (&bit_at_end));
    end

    AST_TC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        carry_in_n |-> tc_n); // R6
    AST_TC_UP_END: assert property (@(posedge clk) disable iff (!rst_n)
        (!carry_in_n && up_dn && count == '1) |-> !tc_n); // R6
    AST_TC_DOWN_END: assert property (@(posedge clk) disable iff (!rst_n)
        (!carry_in_n && !up_dn && count == '0) |-> !tc_n); // R6

endmodule

// File: rtl/updn_cascade_ctr.sv
// Module: top of one cascadable, presettable up/down counter stage.
// Chaining: tc_n drives the next stage's carry_in_n. load_n, cnt_en_n and
// up_dn are shared across the chain.
// Assumes: a single clock; rst_n is synchronous and active low.
module updn_cascade_ctr
    import updn_ctr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic             cnt_en_n,
    input  logic             carry_in_n,
    input  logic             up_dn,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] count,
    output logic             tc_n
);

    ctr_op_e op;

    updn_ctr_op_sel u_sel (
        .rst_n      (rst_n),
        .load_n     (load_n),
        .cnt_en_n   (cnt_en_n),
        .carry_in_n (carry_in_n),
        .up_dn      (up_dn),
        .op         (op)
    );

    updn_ctr_state #(.WIDTH(WIDTH)) u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .op         (op),
        .din        (din),
        .count      (count),
        .load_n     (load_n),
        .cnt_en_n   (cnt_en_n),
        .carry_in_n (carry_in_n),
        .up_dn      (up_dn)
    );

    updn_ctr_tc #(.WIDTH(WIDTH)) u_tc (
        .clk        (clk),
        .rst_n      (rst_n),
        .count      (count),
        .carry_in_n (carry_in_n),
        .up_dn      (up_dn),
        .tc_n       (tc_n)
    );

endmodule

// File: tb/updn_cascade_ctr_tb_top.sv
// Bench: a table of single-edge vectors, then directed tests for reset,
// the combinational terminal flag, and a three-stage chain.
module updn_cascade_ctr_tb_top;

    localparam int W      = 4;
    localparam int NST    = 3;
    localparam int CW     = W * NST;
    localparam int NVEC   = 12;
    localparam int WD_CYC = 100000;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;

    // Single stage under test.
    logic         rst_n, load_n, cnt_en_n, carry_in_n, up_dn;
    logic [W-1:0] din, count;
    logic         tc_n;

    updn_cascade_ctr #(.WIDTH(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .cnt_en_n(cnt_en_n),
        .carry_in_n(carry_in_n), .up_dn(up_dn), .din(din),
        .count(count), .tc_n(tc_n)
    );

    // Chain of stages (R7).
    logic          c_load_n, c_en_n, c_ci_n, c_up;
    logic [CW-1:0] c_din, c_count;
    logic [NST:0]  c_carry;
    assign c_carry[0] = c_ci_n;

    for (genvar s = 0; s < NST; s++) begin : g_stage
        updn_cascade_ctr #(.WIDTH(W)) u_stg (
            .clk(clk), .rst_n(rst_n), .load_n(c_load_n), .cnt_en_n(c_en_n),
            .carry_in_n(c_carry[s]), .up_dn(c_up), .din(c_din[s*W +: W]),
            .count(c_count[s*W +: W]), .tc_n(c_carry[s+1])
        );
    end

    // Vector fields: {load_n, cnt_en_n, carry_in_n, up_dn, din, exp_count, exp_tc_n}.
    // Expectations apply after one edge, with the inputs still held.
    localparam logic [12:0] VEC [NVEC] = '{
        {1'b0,1'b1,1'b1,1'b1, 4'd5,  4'd5,  1'b1},  // R2 load with enables off
        {1'b0,1'b0,1'b0,1'b1, 4'd14, 4'd14, 1'b1},  // R2 load overrides count
        {1'b1,1'b0,1'b0,1'b1, 4'd0,  4'd15, 1'b0},  // R3 up, R6 tc at 15
        {1'b1,1'b0,1'b0,1'b1, 4'd0,  4'd0,  1'b1},  // R3 wrap 15->0
        {1'b1,1'b0,1'b0,1'b0, 4'd0,  4'd15, 1'b1},  // R4 wrap 0->15
        {1'b1,1'b0,1'b0,1'b0, 4'd0,  4'd14, 1'b1},  // R4 down
        {1'b1,1'b1,1'b0,1'b0, 4'd0,  4'd14, 1'b1},  // R5 hold, count enable off
        {1'b1,1'b0,1'b1,1'b1, 4'd0,  4'd14, 1'b1},  // R5 hold, carry-in off
        {1'b0,1'b1,1'b0,1'b0, 4'd0,  4'd0,  1'b0},  // R6 tc at 0 down, load low
        {1'b1,1'b1,1'b0,1'b0, 4'd0,  4'd0,  1'b0},  // R6 count enable does not gate tc
        {1'b0,1'b0,1'b0,1'b1, 4'd15, 4'd15, 1'b0},  // R2/R6 load 15, tc up
        {1'b1,1'b1,1'b1,1'b1, 4'd0,  4'd15, 1'b1}   // R6 carry-in gates tc
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (WD_CYC) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", WD_CYC, 0);
        finish_run();
    end

    initial begin
        rst_n = 1'b0; load_n = 1'b1; cnt_en_n = 1'b1; carry_in_n = 1'b1;
        up_dn = 1'b1; din = '0;
        c_load_n = 1'b1; c_en_n = 1'b1; c_ci_n = 1'b1; c_up = 1'b1; c_din = '0;
        repeat (2) @(negedge clk);
        check("R1 reset count", int'(count), 0);
        check("R1 reset tc_n", int'(tc_n), 1);
        rst_n = 1'b1;

        // Table walk: drive at the falling edge, check at the next falling edge.
        for (int i = 0; i < NVEC; i++) begin
            {load_n, cnt_en_n, carry_in_n, up_dn, din} = VEC[i][12:5];
            @(negedge clk);
            check($sformatf("vec%0d count", i), int'(count), int'(VEC[i][4:1]));
            check($sformatf("vec%0d tc_n", i), int'(tc_n), int'(VEC[i][0]));
        end

        // R1: reset ranks above a simultaneous load.
        rst_n = 1'b0; load_n = 1'b0; din = 4'd9; cnt_en_n = 1'b0; carry_in_n = 1'b0;
        @(negedge clk);
        check("R1 reset over load", int'(count), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 load after reset", int'(count), 9);

        // R6: tc_n follows its inputs within the cycle, with no edge.
        load_n = 1'b0; din = 4'd15; cnt_en_n = 1'b1; carry_in_n = 1'b1; up_dn = 1'b1;
        @(negedge clk);
        load_n = 1'b1;
        #3 check("R6 tc_n off with carry-in off", int'(tc_n), 1);
        carry_in_n = 1'b0;
        #1 check("R6 tc_n on without edge", int'(tc_n), 0);
        up_dn = 1'b0;
        #1 check("R6 direction down at 15", int'(tc_n), 1);
        @(negedge clk);
        check("R5 count held", int'(count), 15);

        // R7: a three-stage chain counts as one 12-bit counter.
        c_load_n = 1'b0; c_din = '0;
        @(negedge clk);
        c_load_n = 1'b1; c_en_n = 1'b0; c_ci_n = 1'b0; c_up = 1'b1;
        repeat (300) @(negedge clk);
        check("R7 chain up 300", int'(c_count), 300);
        c_up = 1'b0;
        repeat (301) @(negedge clk);
        check("R7 chain down wrap", int'(c_count), 4095);
        c_load_n = 1'b0; c_din = 12'hFFE;
        @(negedge clk);
        check("R7 chain preset", int'(c_count), 12'hFFE);
        c_load_n = 1'b1; c_up = 1'b1;
        repeat (3) @(negedge clk);
        check("R7 chain up wrap", int'(c_count), 1);
        c_en_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R7 chain hold", int'(c_count), 1);

        finish_run();
    end

endmodule